// File: doc/BRIEF.md
# Eight-bit compare-match timer with sticky status flags

This block is an eight-bit up-counter with two compare registers, a combined control/status register, an interrupt-enable register and one waveform output. The counter advances by one on every clock where the count-enable input is high. When the new count equals a compare register, or when the count wraps from its top value to zero, a sticky status flag is set. Each flag raises its interrupt line while it is set and its enable bit is 1.

Software clears a flag in two steps. It first reads the status register while the flag is 1, which arms that flag. It then writes 0 to the flag bit. Any write to the status register disarms every flag, and a 1 written to a flag bit never sets it. A transfer controller that services a compare interrupt can also clear that compare flag by pulsing its acknowledge input. When a set event and a clear land in the same cycle, the set wins. A two-bit output-select field sets what compare-match A does to the output pin.

Top module: `cmt8_timer`

## Requirements
- R1: After a synchronous reset, the count reads 0x00, both compare registers read 0xFF, the status register and the enable register read 0x00, the output pin is 0 and all interrupt outputs are 0.
- R2: The count rises by one on each clock where `cnt_en` is high, and holds otherwise. A bus write to the count register (address 0) loads it and overrides the increment in that cycle.
- R3: Flag A (status bit 6) is set on the clock where `cnt_en` is high and the incremented count equals compare register A (address 1).
- R4: Flag B (status bit 7) is set on the clock where `cnt_en` is high and the incremented count equals compare register B (address 2).
- R5: The overflow flag (status bit 5) is set on the clock where `cnt_en` is high and the count goes from 0xFF to 0x00.
- R6: A write of 0 to a flag bit of the status register (address 3) clears that flag only if the register was read while the flag was 1 and no status write came in between. A write of 1 never sets a flag.
- R7: Any write to the status register disarms all flags, so a later write of 0 leaves the flag set until it is read again.
- R8: A one-cycle pulse on `xfer_ack_a` clears flag A, and a pulse on `xfer_ack_b` clears flag B.
- R9: When a set event and a clear (software or acknowledge) fall in the same cycle, the flag ends up set.
- R10: Status bits 1:0 select the action on compare-match A: 00 no change, 01 drive 0, 10 drive 1, 11 toggle. The pin changes on the same edge that sets flag A.
- R11: The enable register (address 4) holds enables at bit 0 for flag A, bit 1 for flag B and bit 2 for overflow. `irq_cmp_a`, `irq_cmp_b` and `irq_ovf` are each the flag AND its enable, and they update on the same edge as the flag.
- R12: Status bit 4 gates the capture request. `irq_cap` is registered and equals `cap_flag` AND bit 4, one edge after both are present.
- R13: Read data comes out on `bus_rdata` one clock after `bus_rd` is sampled and holds until the next read. The status register reads {flagB, flagA, overflow, capture-enable, 0, 0, select[1:0]}, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cnt_en | input | 1 | Count enable |
| xfer_ack_a | input | 1 | Transfer controller serviced compare-A request |
| xfer_ack_b | input | 1 | Transfer controller serviced compare-B request |
| cap_flag | input | 1 | Capture flag from the capture unit |
| tmr_out | output | 1 | Waveform output |
| irq_cmp_a | output | 1 | Compare-A interrupt request |
| irq_cmp_b | output | 1 | Compare-B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cap | output | 1 | Gated capture interrupt request |

## Verification
Two functions can collide on one flag: the set from a compare match, and a clear from an armed software write or a transfer acknowledge. The bench arms flag A with a status read, reloads the count just below compare A, and then in a single cycle raises `cnt_en` and writes 0 to the flag bit. It also raises `cnt_en` together with `xfer_ack_a`. In both cases the flag must read back as 1, and a reference model that steps every clock must agree with the pin, the interrupt lines and the read data.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  // register addresses
  localparam int ADR_CNT  = 0;
  localparam int ADR_CMPA = 1;
  localparam int ADR_CMPB = 2;
  localparam int ADR_CSR  = 3;
  localparam int ADR_IEN  = 4;

  // flag indices inside the flag vector
  localparam int FL_A   = 0;
  localparam int FL_B   = 1;
  localparam int FL_OVF = 2;
  localparam int NFLAG  = 3;

  // status register bit positions (software-visible layout)
  localparam int CSR_FB  = 7;
  localparam int CSR_FA  = 6;
  localparam int CSR_FO  = 5;
  localparam int CSR_CIE = 4;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_TOG  = 2'b11
  } pin_sel_e;
endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CW   = 8,
  parameter int NCMP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            ld_cnt_i,
  input  logic [NCMP-1:0] ld_cmp_i,
  input  logic [CW-1:0]   wval_i,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   cmp_o [NCMP],
  output logic [NCMP-1:0] hit_o,
  output logic            wrap_o
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          step;

  assign step    = en_i & ~ld_cnt_i;
  assign cnt_nxt = cnt_q + CW'(step);
  assign wrap_o  = step & (cnt_q == TOP);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (ld_cnt_i) cnt_q <= wval_i;
    else               cnt_q <= cnt_nxt;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic [CW-1:0] cmp_q;
    always_ff @(posedge clk) begin
      if (rst)              cmp_q <= TOP;
      else if (ld_cmp_i[i]) cmp_q <= wval_i;
    end
    assign cmp_o[i] = cmp_q;
    assign hit_o[i] = step & (cnt_nxt == cmp_q);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (en_i && !ld_cnt_i) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !ld_cnt_i) |=> $stable(cnt_q)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/cmt_flags.sv
module cmt_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] ack_i,
  input  logic          rd_csr_i,
  input  logic          wr_csr_i,
  input  logic [NF-1:0] wbit_i,
  output logic [NF-1:0] flag_o,
  output logic [NF-1:0] flag_d_o
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic flag_q;
    logic arm_q;
    logic clr;
    logic nxt;

    assign clr = (wr_csr_i & ~wbit_i[i] & arm_q) | ack_i[i];
    // a set event outranks any clear in the same cycle
    assign nxt = set_i[i] | (flag_q & ~clr);

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else begin
        flag_q <= nxt;
        if (!nxt || wr_csr_i)      arm_q <= 1'b0;
        else if (rd_csr_i && flag_q) arm_q <= 1'b1;
      end
    end

    assign flag_o[i]   = flag_q;
    assign flag_d_o[i] = nxt;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q); // R9
    AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (rst)
      (!flag_q && !set_i[i]) |=> !flag_q); // R6
    AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (rst)
      (flag_q && !arm_q && !ack_i[i]) |=> flag_q); // R7
  end
endmodule

// File: rtl/cmt_pin.sv
module cmt_pin
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit_i,
  input  logic [1:0] sel_i,
  output logic       pin_o
);
  logic pin_q;
  logic pin_nxt;

  always_comb begin
    pin_nxt = pin_q;
    if (hit_i) begin
      unique case (pin_sel_e'(sel_i))
        PIN_KEEP: pin_nxt = pin_q;
        PIN_LOW:  pin_nxt = 1'b0;
        PIN_HIGH: pin_nxt = 1'b1;
        PIN_TOG:  pin_nxt = ~pin_q;
        default:  pin_nxt = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_nxt;
  end

  assign pin_o = pin_q;

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> $stable(pin_o)); // R10
  AST_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    (hit_i && sel_i == 2'b01) |=> !pin_o); // R10
  AST_PIN_TOG: assert property (@(posedge clk) disable iff (rst)
    (hit_i && sel_i == 2'b11) |=> (pin_o != $past(pin_o))); // R10
endmodule

// File: rtl/cmt8_timer.sv
module cmt8_timer
  import cmt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cnt_en,
  input  logic          xfer_ack_a,
  input  logic          xfer_ack_b,
  input  logic          cap_flag,
  output logic          tmr_out,
  output logic          irq_cmp_a,
  output logic          irq_cmp_b,
  output logic          irq_ovf,
  output logic          irq_cap
);
  localparam int NCMP = 2;

  // address decode
  logic sel_cnt, sel_ca, sel_cb, sel_csr, sel_ien;
  assign sel_cnt = (bus_addr == AW'(ADR_CNT));
  assign sel_ca  = (bus_addr == AW'(ADR_CMPA));
  assign sel_cb  = (bus_addr == AW'(ADR_CMPB));
  assign sel_csr = (bus_addr == AW'(ADR_CSR));
  assign sel_ien = (bus_addr == AW'(ADR_IEN));

  // counter and compare registers
  logic [DW-1:0]   cnt;
  logic [DW-1:0]   cmp [NCMP];
  logic [NCMP-1:0] hit;
  logic            wrap;

  cmt_counter #(.CW(DW), .NCMP(NCMP)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en_i     (cnt_en),
    .ld_cnt_i (bus_wr & sel_cnt),
    .ld_cmp_i ({bus_wr & sel_cb, bus_wr & sel_ca}),
    .wval_i   (bus_wdata),
    .cnt_o    (cnt),
    .cmp_o    (cmp),
    .hit_o    (hit),
    .wrap_o   (wrap)
  );

  // status flags
  logic [NFLAG-1:0] set_v, ack_v, wbit_v, flag, flag_d;
  always_comb begin
    set_v          = '0;
    ack_v          = '0;
    wbit_v         = '0;
    set_v[FL_A]    = hit[0];
    set_v[FL_B]    = hit[1];
    set_v[FL_OVF]  = wrap;
    ack_v[FL_A]    = xfer_ack_a;
    ack_v[FL_B]    = xfer_ack_b;
    wbit_v[FL_A]   = bus_wdata[CSR_FA];
    wbit_v[FL_B]   = bus_wdata[CSR_FB];
    wbit_v[FL_OVF] = bus_wdata[CSR_FO];
  end

  cmt_flags #(.NF(NFLAG)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_v),
    .ack_i    (ack_v),
    .rd_csr_i (bus_rd & sel_csr),
    .wr_csr_i (bus_wr & sel_csr),
    .wbit_i   (wbit_v),
    .flag_o   (flag),
    .flag_d_o (flag_d)
  );

  // control fields
  logic [1:0]       osel_q;
  logic             cie_q, cie_d;
  logic [NFLAG-1:0] ien_q, ien_d;

  assign cie_d = (bus_wr && sel_csr) ? bus_wdata[CSR_CIE] : cie_q;
  assign ien_d = (bus_wr && sel_ien) ? bus_wdata[NFLAG-1:0] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      osel_q <= 2'b00;
      cie_q  <= 1'b0;
      ien_q  <= '0;
    end else begin
      if (bus_wr && sel_csr) osel_q <= bus_wdata[1:0];
      cie_q <= cie_d;
      ien_q <= ien_d;
    end
  end

  // waveform output
  cmt_pin u_pin (
    .clk   (clk),
    .rst   (rst),
    .hit_i (hit[0]),
    .sel_i (osel_q),
    .pin_o (tmr_out)
  );

  // registered interrupt requests, aligned with the flag edge
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_cmp_a <= 1'b0;
      irq_cmp_b <= 1'b0;
      irq_ovf   <= 1'b0;
      irq_cap   <= 1'b0;
    end else begin
      irq_cmp_a <= flag_d[FL_A]   & ien_d[FL_A];
      irq_cmp_b <= flag_d[FL_B]   & ien_d[FL_B];
      irq_ovf   <= flag_d[FL_OVF] & ien_d[FL_OVF];
      irq_cap   <= cap_flag & cie_d;
    end
  end

  // registered read port
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_cnt)      rd_mux = cnt;
    else if (sel_ca)  rd_mux = cmp[0];
    else if (sel_cb)  rd_mux = cmp[1];
    else if (sel_csr) rd_mux = DW'({flag[FL_B], flag[FL_A], flag[FL_OVF], cie_q, 2'b00, osel_q});
    else if (sel_ien) rd_mux = DW'(ien_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R13
  AST_CAP_GATE: assert property (@(posedge clk) disable iff (rst)
    !cap_flag |=> !irq_cap); // R12
  AST_IRQ_A_FLAG: assert property (@(posedge clk) disable iff (rst)
    (hit[0] && ien_d[FL_A]) |=> irq_cmp_a); // R11
endmodule

// File: tb/tb_cmt8_timer.sv
module tb_cmt8_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_en = 1'b0, xfer_ack_a = 1'b0, xfer_ack_b = 1'b0, cap_flag = 1'b0;
  logic       tmr_out, irq_cmp_a, irq_cmp_b, irq_ovf, irq_cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt8_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en),
    .xfer_ack_a(xfer_ack_a), .xfer_ack_b(xfer_ack_b), .cap_flag(cap_flag),
    .tmr_out(tmr_out), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b),
    .irq_ovf(irq_ovf), .irq_cap(irq_cap)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  // ---------------- reference model ----------------
  int m_cnt, m_ca, m_cb, m_os, m_cie, m_ien, m_rd;
  bit m_fa, m_fb, m_fo, m_aa, m_ab, m_ao, m_pin;
  bit m_ia, m_ib, m_io, m_ic;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_ca = 255; m_cb = 255; m_os = 0; m_cie = 0; m_ien = 0; m_rd = 0;
      m_fa = 0; m_fb = 0; m_fo = 0; m_aa = 0; m_ab = 0; m_ao = 0; m_pin = 0;
      m_ia = 0; m_ib = 0; m_io = 0; m_ic = 0;
    end else begin
      bit ws, rs, inc, ha, hb, wo, na, nb, no;
      int nc;
      ws  = bus_wr && bus_addr == 3;
      rs  = bus_rd && bus_addr == 3;
      inc = cnt_en && !(bus_wr && bus_addr == 0);
      nc  = (m_cnt + (inc ? 1 : 0)) % 256;
      ha  = inc && nc == m_ca;
      hb  = inc && nc == m_cb;
      wo  = inc && m_cnt == 255;
      na  = ha || (m_fa && !((ws && !bus_wdata[6] && m_aa) || xfer_ack_a));
      nb  = hb || (m_fb && !((ws && !bus_wdata[7] && m_ab) || xfer_ack_b));
      no  = wo || (m_fo && !(ws && !bus_wdata[5] && m_ao));
      if (bus_rd) begin
        case (bus_addr)
          0: m_rd = m_cnt;
          1: m_rd = m_ca;
          2: m_rd = m_cb;
          3: m_rd = (m_fb << 7) | (m_fa << 6) | (m_fo << 5) | (m_cie << 4) | m_os;
          4: m_rd = m_ien;
          default: m_rd = 0;
        endcase
      end
      if (ha) begin
        if (m_os == 1) m_pin = 0;
        else if (m_os == 2) m_pin = 1;
        else if (m_os == 3) m_pin = !m_pin;
      end
      m_aa = !na ? 0 : ws ? 0 : (rs && m_fa) ? 1 : m_aa;
      m_ab = !nb ? 0 : ws ? 0 : (rs && m_fb) ? 1 : m_ab;
      m_ao = !no ? 0 : ws ? 0 : (rs && m_fo) ? 1 : m_ao;
      m_fa = na; m_fb = nb; m_fo = no;
      m_cnt = (bus_wr && bus_addr == 0) ? int'(bus_wdata) : nc;
      if (bus_wr && bus_addr == 1) m_ca = bus_wdata;
      if (bus_wr && bus_addr == 2) m_cb = bus_wdata;
      if (ws) begin m_os = bus_wdata[1:0]; m_cie = bus_wdata[4]; end
      if (bus_wr && bus_addr == 4) m_ien = bus_wdata[2:0];
      m_ia = m_fa && m_ien[0];
      m_ib = m_fb && m_ien[1];
      m_io = m_fo && m_ien[2];
      m_ic = cap_flag && m_cie;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 pin vs model", tmr_out, m_pin);
      chk("R11 irq_cmp_a vs model", irq_cmp_a, m_ia);
      chk("R11 irq_cmp_b vs model", irq_cmp_b, m_ib);
      chk("R11 irq_ovf vs model", irq_ovf, m_io);
      chk("R12 irq_cap vs model", irq_cap, m_ic);
      chk("R13 rdata vs model", bus_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk); bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); bus_addr = 3'(a); bus_rd = 1;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic run(input int n);
    @(negedge clk); cnt_en = 1;
    repeat (n) @(negedge clk);
    cnt_en = 0;
  endtask

  task automatic ack_a();
    @(negedge clk); xfer_ack_a = 1;
    @(negedge clk); xfer_ack_a = 0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state
    chk("R1 pin after reset", tmr_out, 0);
    chk("R1 irq lines after reset", {irq_cmp_a, irq_cmp_b, irq_ovf, irq_cap}, 0);
    rd(0, v); chk("R1 count reset", v, 8'h00);
    rd(1, v); chk("R1 compare A reset", v, 8'hFF);
    rd(3, v); chk("R1 status reset", v, 8'h00);
    rd(4, v); chk("R1 enable reset", v, 8'h00);
    rd(7, v); chk("R13 unused address", v, 8'h00);

    // setup
    wr(1, 3); wr(2, 5); wr(4, 7); wr(3, 8'h03);
    rd(2, v); chk("R13 compare B readback", v, 8'h05);

    // compare A hit with toggle
    run(3);
    chk("R10 toggle on match A", tmr_out, 1);
    chk("R11 irq A raised", irq_cmp_a, 1);
    rd(0, v); chk("R2 count after three enables", v, 8'h03);
    rd(3, v); chk("R3 flag A set", v, 8'h43);
    wr(3, 8'h03);
    rd(3, v); chk("R6 armed write clears A", v, 8'h03);

    // compare B hit, unarmed clear attempts
    run(2);
    wr(3, 8'h03);
    rd(3, v); chk("R6 unarmed write keeps B", v, 8'h83);
    wr(3, 8'h83);
    wr(3, 8'h03);
    rd(3, v); chk("R7 write disarms", v, 8'h83);
    wr(3, 8'h03);
    rd(3, v); chk("R6 rearmed write clears B", v, 8'h03);
    rd(0, v); chk("R4 count at B match", v, 8'h05);

    // transfer acknowledge clear
    wr(0, 2); run(1);
    chk("R10 second toggle", tmr_out, 0);
    ack_a();
    rd(3, v); chk("R8 ack clears A", v, 8'h03);
    chk("R11 irq A dropped", irq_cmp_a, 0);

    // set and clear in one cycle
    wr(0, 2); run(1);
    rd(3, v);
    wr(0, 2);
    @(negedge clk); cnt_en = 1; bus_addr = 3; bus_wdata = 8'h03; bus_wr = 1;
    @(negedge clk); cnt_en = 0; bus_wr = 0;
    rd(3, v); chk("R9 set beats software clear", v, 8'h43);
    wr(0, 2);
    @(negedge clk); cnt_en = 1; xfer_ack_a = 1;
    @(negedge clk); cnt_en = 0; xfer_ack_a = 0;
    rd(3, v); chk("R9 set beats ack clear", v, 8'h43);
    ack_a();

    // overflow
    wr(0, 8'hFF); run(1);
    rd(3, v); chk("R5 overflow flag", v, 8'h23);
    chk("R11 irq ovf raised", irq_ovf, 1);
    rd(0, v); chk("R5 count wrapped", v, 8'h00);
    rd(3, v);
    wr(3, 8'h03);

    // output-select modes
    wr(3, 8'h02); wr(0, 2); run(1);
    chk("R10 select 10 drives 1", tmr_out, 1);
    wr(3, 8'h00); wr(0, 2); run(1);
    chk("R10 select 00 keeps pin", tmr_out, 1);
    wr(3, 8'h01); wr(0, 2); run(1);
    chk("R10 select 01 drives 0", tmr_out, 0);

    // interrupt enables
    wr(4, 0);
    chk("R11 irq A masked", irq_cmp_a, 0);
    wr(4, 1);
    chk("R11 irq A unmasked", irq_cmp_a, 1);

    // capture gating
    @(negedge clk); cap_flag = 1;
    @(negedge clk);
    chk("R12 capture masked", irq_cap, 0);
    wr(3, 8'hF1);
    chk("R12 capture enabled", irq_cap, 1);
    @(negedge clk); cap_flag = 0;
    @(negedge clk);
    chk("R12 capture follows input", irq_cap, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule